// File: doc/BRIEF.md
# Add/Subtract Condition Code Unit

This block is a width-parameterised integer add and subtract datapath. Besides the wrapped result, it produces the four condition flags that branch logic needs: negative, zero, signed overflow and carry. Subtraction takes the destination operand minus the source operand. On subtraction the carry flag means a borrow, and on addition it means a carry-out.

The arithmetic and flag logic is combinational. It feeds one output register stage that loads only when the input strobe `in_valid` is high. A strobe at a clock edge yields `out_valid` together with the matching result and flags on the next cycle. The registers hold their contents while no strobe arrives, so a consumer can sample them at leisure. The flags leave the block as one packed 4-bit vector.

Top module: `addsub_flags`

## Requirements
- R1: The flag vector is packed as N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. For example, 65535 + 1 gives flags 4'b0101.
- R2: With `op_sub` = 0 the result is `dst + src` modulo 2^W.
- R3: With `op_sub` = 1 the result is `dst - src` modulo 2^W. For example, dst 1 and src 32768 give 32769 with flags 4'b1011.
- R4: N equals the most significant bit of the result.
- R5: Z is set exactly when the result is zero.
- R6: On addition, V is set when both operands have the same sign and the sign of the result differs from it.
- R7: On subtraction, V is set when the operands' signs differ and the sign of the result equals the source's sign.
- R8: On addition, C is the carry out of the most significant bit.
- R9: On subtraction, C is set exactly when `src` is unsigned-greater than `dst`.
- R10: The result and flags for an operation strobed at a rising edge appear at the outputs after that edge, and `out_valid` is high for exactly the cycles that follow a strobed edge.
- R11: While `in_valid` is low, changes on `src`, `dst` and `op_sub` leave `result` and `flags` unchanged.
- R12: While reset is active, `out_valid`, `result` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that loads the output stage |
| op_sub | input | 1 | 0 = add, 1 = subtract (dst - src) |
| src | input | W | Source operand |
| dst | input | W | Destination operand |
| out_valid | output | 1 | High for the cycle after a strobe |
| result | output | W | Registered result |
| flags | output | 4 | Registered flags {N,Z,V,C} |

## Verification
Each result is due exactly one rising edge after its strobe: the bench drives inputs on falling edges, and the registered outputs then change at the next rising edge. The driver pushes the independently computed result and flags into a queue when it drives a strobe. The monitor samples on every falling edge and pops one entry each time `out_valid` is high, so each comparison lands in the half-cycle after the output register has loaded. Idle stretches with changing operands then confirm that the registered values hold and that `out_valid` stays low.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         op_sub,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [3:0]   flags
);
  localparam int MSB = W - 1;

  logic [W:0]   wide;
  logic [W-1:0] res_c;
  logic         n_c, z_c, v_c, c_c;

  assign wide  = op_sub ? ({1'b0, dst} - {1'b0, src}) : ({1'b0, dst} + {1'b0, src});
  assign res_c = wide[W-1:0];
  assign n_c   = res_c[MSB];
  assign z_c   = (res_c == '0);
  assign c_c   = wide[W];
  assign v_c   = op_sub ? ((dst[MSB] != src[MSB]) && (res_c[MSB] == src[MSB]))
                        : ((dst[MSB] == src[MSB]) && (res_c[MSB] != dst[MSB]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= 4'b0000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_c;
        flags  <= {n_c, z_c, v_c, c_c};
      end
    end
  end

  // R4
  n_is_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags[3] == result[MSB]));

  // R5
  z_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags[2] == (result == '0)));

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags)));

  // R9
  equal_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sub && (src == dst)) |=> (result == '0 && flags == 4'b0100));
endmodule

// File: tb/addsub_flags_bench.sv
module addsub_flags_bench;
  localparam int W = 16;

  typedef struct {
    logic         sub;
    logic [W-1:0] res;
    logic [3:0]   fl;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         op_sub = 1'b0;
  logic [W-1:0] src = '0;
  logic [W-1:0] dst = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic [3:0]   flags;

  int total = 0;
  int bad = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  addsub_flags #(.W(W)) u_addsub_flags (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .src(src), .dst(dst), .out_valid(out_valid), .result(result), .flags(flags)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic s, input logic [W-1:0] a_src, input logic [W-1:0] a_dst);
    exp_t e;
    int sd, ss, sr;
    sd = int'($signed(a_dst));
    ss = int'($signed(a_src));
    sr = s ? (sd - ss) : (sd + ss);
    e.sub = s;
    if (s) e.res = W'(int'(a_dst) - int'(a_src));
    else   e.res = W'(int'(a_dst) + int'(a_src));
    e.fl[3] = (e.res >= (1 << (W-1)));
    e.fl[2] = (e.res == 0);
    e.fl[1] = (sr > (1 << (W-1)) - 1) || (sr < -(1 << (W-1)));
    e.fl[0] = s ? (int'(a_src) > int'(a_dst)) : ((int'(a_dst) + int'(a_src)) >= (1 << W));
    return e;
  endfunction

  task automatic send(input logic s, input logic [W-1:0] a_src, input logic [W-1:0] a_dst);
    @(negedge clk);
    op_sub = s; src = a_src; dst = a_dst; in_valid = 1'b1;
    sb.push_back(model(s, a_src, a_dst));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic flag_chk(input exp_t e, input logic [3:0] fl, input logic [W-1:0] want);
    check(e.sub ? "R1 R3 packed" : "R1 R2 packed", int'(fl), int'(want[3:0]));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check("R10 unexpected out_valid", 1, 0);
        end else begin
          e = sb.pop_front();
          check(e.sub ? "R3 result" : "R2 result", int'(result), int'(e.res));
          check("R4 N", int'(flags[3]), int'(e.fl[3]));
          check("R5 Z", int'(flags[2]), int'(e.fl[2]));
          check(e.sub ? "R7 V" : "R6 V", int'(flags[1]), int'(e.fl[1]));
          check(e.sub ? "R9 C" : "R8 C", int'(flags[0]), int'(e.fl[0]));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] lf;
    logic [W-1:0] hr;
    logic [3:0]   hf;
    repeat (3) @(negedge clk);
    check("R12 out_valid", int'(out_valid), 0);
    check("R12 result", int'(result), 0);
    check("R12 flags", int'(flags), 0);
    rst_n = 1'b1;

    send(1'b0, 16'd1, 16'd65535);
    idle();
    @(negedge clk);
    check("R1 add wrap flags", int'(flags), 4'b0101);
    check("R10 valid drop", int'(out_valid), 0);

    send(1'b0, 16'd32767, 16'd1);
    send(1'b0, 16'd1, 16'd32768);
    send(1'b0, 16'd0, 16'd0);
    send(1'b1, 16'd1, 16'd1);
    send(1'b1, 16'd32768, 16'd1);
    idle();
    @(negedge clk);
    check("R3 sub 1-32768 result", int'(result), 32769);
    check("R1 sub 1-32768 flags", int'(flags), 4'b1011);

    send(1'b1, 16'd65535, 16'd1);
    send(1'b1, 16'd0, 16'd32768);
    send(1'b1, 16'd32767, 16'd32768);
    send(1'b0, 16'd32768, 16'd32768);
    idle();

    lf = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] a, b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b = lf;
      send(lf[0], a, b);
      if (lf[3]) idle();
    end
    idle();
    repeat (2) @(negedge clk);

    hr = result;
    hf = flags;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      op_sub = ~op_sub; src = src + 16'd77; dst = dst ^ 16'h5A5A;
      @(negedge clk);
      check("R11 result hold", int'(result), int'(hr));
      check("R11 flags hold", int'(flags), int'(hf));
      check("R10 no valid when idle", int'(out_valid), 0);
    end

    check("R10 queue drained", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule